// File: doc/BRIEF.md
# 16-bit Address Arithmetic Unit

This unit performs the pointer arithmetic of a small 8-bit processor core. It forms the sum of two register pairs for the HL accumulate, and adds a signed byte offset to the stack pointer. That second result is meant either for the stack pointer itself or for HL, and the two selects give the same value. It also steps a pair or the stack pointer by one in either direction. For two-byte stack transfers it produces the two byte addresses and the final stack pointer. For relative jumps it decides the condition and forms the destination.

The caller presents an operation select, two 16-bit operands, an 8-bit immediate or displacement, a condition code and the current flag nibble, with a valid strobe. One cycle later the registered outputs carry the 16-bit result, up to two memory byte addresses, the new flags and a branch-taken bit, under an output valid strobe. The memory accesses and the register file belong to the surrounding core.

Top module: `addr_arith_unit`

## Requirements
- R1: After reset, out_valid, result, mem_addr0, mem_addr1, flags_out and taken are all zero.
- R2: An operation presented with in_valid high at a rising edge appears on the outputs after that edge, with out_valid high for exactly one cycle. Operations may be issued on back-to-back cycles. A cycle with in_valid low gives out_valid low after the next edge.
- R3: Op 1 (pair add) returns opa+opb modulo 65536. The flag nibble is {Z,N,H,C} at bits 3..0. Z is copied from flags_in, N is cleared, H is the carry out of bit 11 and C is the carry out of bit 15.
- R4: Op 2 (offset to SP) and op 3 (offset to HL) both return opa plus imm sign-extended to 16 bits, modulo 65536. They clear Z and N, set H on a carry out of bit 11 and set C on a carry out of bit 15 of that 16-bit sum.
- R5: Op 4 returns opa+1 and op 5 returns opa-1, both wrapping modulo 65536. Both leave flags_out equal to flags_in.
- R6: Op 6 (push) gives mem_addr0 = opa-1 for the high byte, mem_addr1 = opa-2 for the low byte and result = opa-2, all wrapping. Flags are unchanged.
- R7: Op 7 (pop) gives mem_addr0 = opa for the low byte, mem_addr1 = opa+1 for the high byte and result = opa+2, all wrapping. Op 8 (pop into accumulator/flags) does the same, but flags_out takes opb[7:4], so the popped flag byte's low four bits are dropped.
- R8: Op 9 (relative branch) tests cond: 0 always, 1 Z clear, 2 Z set, 3 C clear, 4 C set, and 5-7 never. When the test passes, result = opa + sign-extended imm, modulo 65536. Flags are unchanged.
- R9: taken is high only for op 9 with a passing condition. For a failing condition the result is opa, the fall-through address.
- R10: Op 0 and the unused codes 10-15 return opa and copy flags_in. Every operation other than 6, 7 and 8 drives both memory addresses to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation select |
| cond | input | 3 | Branch condition code |
| opa | input | 16 | First operand: HL, SP, pair or fall-through PC |
| opb | input | 16 | Second operand: added pair, or popped word for op 8 |
| imm | input | 8 | Signed offset or displacement |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Result strobe |
| result | output | 16 | 16-bit result |
| mem_addr0 | output | 16 | First stack byte address |
| mem_addr1 | output | 16 | Second stack byte address |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| taken | output | 1 | Branch taken |

## Verification
The two carry detectors of the 16-bit adder can fire in the same operation. Adding 0x0001 to 0xFFFF, as a pair add or as a +1 offset to SP, raises H and C together while the sum wraps to zero. In the pair-add case a set Z must also survive. The bench provokes these cases with boundary operands and compares every flag bit and the result against a model built from the requirements. It also issues operations back to back, so that each result must be paired with the right request in the scoreboard.

// File: rtl/aau_pkg.sv
package aau_pkg;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_ADD_PAIR  = 4'd1,
    OP_SP_OFS    = 4'd2,
    OP_HL_SP_OFS = 4'd3,
    OP_INC       = 4'd4,
    OP_DEC       = 4'd5,
    OP_PUSH      = 4'd6,
    OP_POP       = 4'd7,
    OP_POP_FLAGS = 4'd8,
    OP_BRANCH    = 4'd9
  } aau_op_e;

  typedef enum logic [1:0] {
    SM_INC  = 2'd0,
    SM_DEC  = 2'd1,
    SM_PUSH = 2'd2,
    SM_POP  = 2'd3
  } aau_stk_e;

  localparam logic [2:0] CC_ALWAYS = 3'd0;
  localparam logic [2:0] CC_NZ     = 3'd1;
  localparam logic [2:0] CC_Z      = 3'd2;
  localparam logic [2:0] CC_NC     = 3'd3;
  localparam logic [2:0] CC_C      = 3'd4;

  localparam int unsigned FZ = 3;
  localparam int unsigned FN = 2;
  localparam int unsigned FH = 1;
  localparam int unsigned FC = 0;

endpackage

// File: rtl/aau_add16.sv
module aau_add16 #(
  parameter int unsigned W        = 16,
  parameter int unsigned DISP_W   = 8,
  parameter int unsigned HALF_BIT = 12
) (
  input  logic [W-1:0]      base,
  input  logic [W-1:0]      pair,
  input  logic [DISP_W-1:0] ofs,
  input  logic              use_ofs,
  output logic [W-1:0]      sum,
  output logic              half_co,
  output logic              full_co
);
  localparam int unsigned EXT_W = W - DISP_W;

  logic [W-1:0]      addend;
  logic [W:0]        full_sum;
  logic [HALF_BIT:0] low_sum;

  always_comb begin
    addend   = use_ofs ? {{EXT_W{ofs[DISP_W-1]}}, ofs} : pair;
    full_sum = {1'b0, base} + {1'b0, addend};
    low_sum  = {1'b0, base[HALF_BIT-1:0]} + {1'b0, addend[HALF_BIT-1:0]};
    sum      = full_sum[W-1:0];
    half_co  = low_sum[HALF_BIT];
    full_co  = full_sum[W];
  end
endmodule

// File: rtl/aau_stack.sv
module aau_stack
  import aau_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  aau_stk_e     mode,
  input  logic [W-1:0] ptr,
  output logic [W-1:0] next_ptr,
  output logic [W-1:0] addr_first,
  output logic [W-1:0] addr_second
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [W-1:0] up1, up2, dn1, dn2;

  always_comb begin
    up1 = ptr + ONE;
    up2 = ptr + TWO;
    dn1 = ptr - ONE;
    dn2 = ptr - TWO;
    next_ptr    = ptr;
    addr_first  = '0;
    addr_second = '0;
    case (mode)
      SM_INC:  next_ptr = up1;
      SM_DEC:  next_ptr = dn1;
      SM_PUSH: begin
        next_ptr    = dn2;
        addr_first  = dn1;
        addr_second = dn2;
      end
      SM_POP: begin
        next_ptr    = up2;
        addr_first  = ptr;
        addr_second = up1;
      end
      default: next_ptr = ptr;
    endcase
  end
endmodule

// File: rtl/aau_branch.sv
module aau_branch
  import aau_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic [2:0]        cc,
  input  logic              zf,
  input  logic              cf,
  input  logic [W-1:0]      pc_next,
  input  logic [DISP_W-1:0] disp,
  output logic [W-1:0]      target,
  output logic              cond_ok
);
  localparam int unsigned EXT_W = W - DISP_W;

  logic [W-1:0] jump_to;

  always_comb begin
    case (cc)
      CC_ALWAYS: cond_ok = 1'b1;
      CC_NZ:     cond_ok = !zf;
      CC_Z:      cond_ok = zf;
      CC_NC:     cond_ok = !cf;
      CC_C:      cond_ok = cf;
      default:   cond_ok = 1'b0;
    endcase
    jump_to = pc_next + {{EXT_W{disp[DISP_W-1]}}, disp};
    target  = cond_ok ? jump_to : pc_next;
  end
endmodule

// File: rtl/addr_arith_unit.sv
module addr_arith_unit
  import aau_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DISP_W      = 8,
  parameter int unsigned HALF_BIT    = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [2:0]        cond,
  input  logic [ADDR_W-1:0] opa,
  input  logic [ADDR_W-1:0] opb,
  input  logic [DISP_W-1:0] imm,
  input  logic [3:0]        flags_in,
  output logic              out_valid,
  output logic [ADDR_W-1:0] result,
  output logic [ADDR_W-1:0] mem_addr0,
  output logic [ADDR_W-1:0] mem_addr1,
  output logic [3:0]        flags_out,
  output logic              taken
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  aau_op_e op_e;
  assign op_e = aau_op_e'(op);

  // datapath pieces
  logic              use_ofs;
  logic [ADDR_W-1:0] add_sum;
  logic              add_h, add_c;
  aau_stk_e          stk_mode;
  logic [ADDR_W-1:0] stk_next, stk_a0, stk_a1;
  logic [ADDR_W-1:0] br_target;
  logic              br_ok;

  aau_add16 #(.W(ADDR_W), .DISP_W(DISP_W), .HALF_BIT(HALF_BIT)) u_add (
    .base(opa), .pair(opb), .ofs(imm), .use_ofs(use_ofs),
    .sum(add_sum), .half_co(add_h), .full_co(add_c)
  );

  aau_stack #(.W(ADDR_W)) u_stk (
    .mode(stk_mode), .ptr(opa), .next_ptr(stk_next),
    .addr_first(stk_a0), .addr_second(stk_a1)
  );

  aau_branch #(.W(ADDR_W), .DISP_W(DISP_W)) u_br (
    .cc(cond), .zf(flags_in[FZ]), .cf(flags_in[FC]),
    .pc_next(opa), .disp(imm), .target(br_target), .cond_ok(br_ok)
  );

  // next-state selection
  logic [ADDR_W-1:0] res_d, a0_d, a1_d;
  logic [3:0]        fl_d;
  logic              tk_d;

  always_comb begin
    use_ofs  = 1'b0;
    stk_mode = SM_INC;
    res_d    = opa;
    a0_d     = '0;
    a1_d     = '0;
    fl_d     = flags_in;
    tk_d     = 1'b0;
    case (op_e)
      OP_ADD_PAIR: begin
        res_d = add_sum;
        fl_d  = {flags_in[FZ], 1'b0, add_h, add_c};
      end
      OP_SP_OFS, OP_HL_SP_OFS: begin
        use_ofs = 1'b1;
        res_d   = add_sum;
        fl_d    = {1'b0, 1'b0, add_h, add_c};
      end
      OP_INC: begin
        stk_mode = SM_INC;
        res_d    = stk_next;
      end
      OP_DEC: begin
        stk_mode = SM_DEC;
        res_d    = stk_next;
      end
      OP_PUSH: begin
        stk_mode = SM_PUSH;
        res_d    = stk_next;
        a0_d     = stk_a0;
        a1_d     = stk_a1;
      end
      OP_POP, OP_POP_FLAGS: begin
        stk_mode = SM_POP;
        res_d    = stk_next;
        a0_d     = stk_a0;
        a1_d     = stk_a1;
        if (op_e == OP_POP_FLAGS) fl_d = opb[7:4];
      end
      OP_BRANCH: begin
        res_d = br_target;
        tk_d  = br_ok;
      end
      default: begin
        res_d = opa;
      end
    endcase
  end

  // output registers with explicit clock enable
  logic       cap_en;
  logic [3:0] op_q;

  assign cap_en = in_valid;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      mem_addr0 <= '0;
      mem_addr1 <= '0;
      flags_out <= '0;
      taken     <= 1'b0;
      op_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (cap_en) begin
        result    <= res_d;
        mem_addr0 <= a0_d;
        mem_addr1 <= a1_d;
        flags_out <= fl_d;
        taken     <= tk_d;
        op_q      <= op;
      end
    end
  end

  // assertions guarding the registered outputs
  assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);
  assert_pair_flags_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op == OP_ADD_PAIR) |=> (flags_out[FZ] == $past(flags_in[FZ])) && !flags_out[FN]);
  assert_ofs_flags_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && (op == OP_SP_OFS || op == OP_HL_SP_OFS)) |=> !flags_out[FZ] && !flags_out[FN]);
  assert_step_flags_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && (op == OP_INC || op == OP_DEC)) |=> flags_out == $past(flags_in));
  assert_push_addr_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && op_q == OP_PUSH) |->
      (ADDR_W'(mem_addr0 - mem_addr1) == ADDR_W'(1)) && (result == mem_addr1));
  assert_pop_addr_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && (op_q == OP_POP || op_q == OP_POP_FLAGS)) |->
      (ADDR_W'(mem_addr1 - mem_addr0) == ADDR_W'(1)) && (ADDR_W'(result - mem_addr1) == ADDR_W'(1)));
  assert_taken_branch_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && taken) |-> op_q == OP_BRANCH);
  assert_popflags_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op == OP_POP_FLAGS) |=> flags_out == $past(opb[7:4]));
endmodule

// File: tb/sim_addr_arith_unit.sv
`timescale 1ns/1ps
module sim_addr_arith_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [2:0]  cond;
  logic [15:0] opa, opb;
  logic [7:0]  imm;
  logic [3:0]  flags_in;
  logic        out_valid;
  logic [15:0] result, mem_addr0, mem_addr1;
  logic [3:0]  flags_out;
  logic        taken;

  always #10 clk = ~clk;

  addr_arith_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cond(cond),
    .opa(opa), .opb(opb), .imm(imm), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .mem_addr0(mem_addr0),
    .mem_addr1(mem_addr1), .flags_out(flags_out), .taken(taken)
  );

  typedef struct {
    logic [15:0] r;
    logic [15:0] a0;
    logic [15:0] a1;
    logic [3:0]  f;
    logic        t;
    string       req;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic item_t model(input logic [3:0] o, input logic [2:0] c,
                                  input logic [15:0] a, input logic [15:0] b,
                                  input logic [7:0] d, input logic [3:0] f);
    item_t it;
    logic [16:0] s17;
    logic [12:0] s13;
    logic [15:0] sx;
    logic        pass;
    sx = {{8{d[7]}}, d};
    it.r = a; it.a0 = 16'h0; it.a1 = 16'h0; it.f = f; it.t = 1'b0; it.req = "R10";
    case (o)
      4'd1: begin
        s17 = {1'b0, a} + {1'b0, b};
        s13 = {1'b0, a[11:0]} + {1'b0, b[11:0]};
        it.r = s17[15:0]; it.f = {f[3], 1'b0, s13[12], s17[16]}; it.req = "R3";
      end
      4'd2, 4'd3: begin
        s17 = {1'b0, a} + {1'b0, sx};
        s13 = {1'b0, a[11:0]} + {1'b0, sx[11:0]};
        it.r = s17[15:0]; it.f = {2'b00, s13[12], s17[16]}; it.req = "R4";
      end
      4'd4: begin it.r = a + 16'd1; it.req = "R5"; end
      4'd5: begin it.r = a - 16'd1; it.req = "R5"; end
      4'd6: begin it.r = a - 16'd2; it.a0 = a - 16'd1; it.a1 = a - 16'd2; it.req = "R6"; end
      4'd7, 4'd8: begin
        it.r = a + 16'd2; it.a0 = a; it.a1 = a + 16'd1; it.req = "R7";
        if (o == 4'd8) it.f = b[7:4];
      end
      4'd9: begin
        case (c)
          3'd0: pass = 1'b1;
          3'd1: pass = !f[3];
          3'd2: pass = f[3];
          3'd3: pass = !f[0];
          3'd4: pass = f[0];
          default: pass = 1'b0;
        endcase
        it.t = pass; it.r = pass ? a + sx : a; it.req = pass ? "R8" : "R9";
      end
      default: ;
    endcase
    return it;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [2:0] c, input logic [15:0] a,
                       input logic [15:0] b, input logic [7:0] d, input logic [3:0] f);
    @(negedge clk);
    in_valid = 1'b1; op = o; cond = c; opa = a; opb = b; imm = d; flags_in = f;
    q.push_back(model(o, c, a, b, d, f));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2 out_valid actual=1 expected=0 (no pending request)");
      end else begin
        item_t e;
        e = q.pop_front();
        chk(e.req, "result", result, e.r);
        chk(e.req, "mem_addr0", mem_addr0, e.a0);
        chk(e.req, "mem_addr1", mem_addr1, e.a1);
        chk(e.req, "flags", {12'h0, flags_out}, {12'h0, e.f});
        chk((e.t || e.req == "R9") ? "R9" : e.req, "taken", {15'h0, taken}, {15'h0, e.t});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = 4'd0; cond = 3'd0;
    opa = 16'h0; opb = 16'h0; imm = 8'h0; flags_in = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", "out_valid", {15'h0, out_valid}, 16'h0);
    chk("R1", "result", result, 16'h0);
    chk("R1", "mem_addr0", mem_addr0, 16'h0);
    chk("R1", "mem_addr1", mem_addr1, 16'h0);
    chk("R1", "flags", {12'h0, flags_out}, 16'h0);
    chk("R1", "taken", {15'h0, taken}, 16'h0);

    // R3 pair add boundaries; 0xFFFF+1 raises H and C together, Z kept
    drive(4'd1, 3'd0, 16'h0FFF, 16'h0001, 8'h00, 4'h0);
    drive(4'd1, 3'd0, 16'hFFFF, 16'h0001, 8'h00, 4'h8);
    drive(4'd1, 3'd0, 16'h7FFF, 16'h7FFF, 8'h00, 4'h7);
    drive(4'd1, 3'd0, 16'h8000, 16'h8000, 8'h00, 4'hF);
    // R4 offset to SP / HL
    drive(4'd2, 3'd0, 16'hFFFF, 16'h1234, 8'h01, 4'hF);
    drive(4'd3, 3'd0, 16'h0000, 16'h0000, 8'h80, 4'hF);
    drive(4'd2, 3'd0, 16'h0FFF, 16'h0000, 8'h7F, 4'h0);
    drive(4'd3, 3'd0, 16'h7FFF, 16'h0000, 8'hFF, 4'h8);
    // R5 step with wrap
    drive(4'd4, 3'd0, 16'hFFFF, 16'h0, 8'h0, 4'hF);
    drive(4'd5, 3'd0, 16'h0000, 16'h0, 8'h0, 4'h5);
    // R6 push / R7 pop with wrap
    drive(4'd6, 3'd0, 16'h0000, 16'h0, 8'h0, 4'hA);
    drive(4'd6, 3'd0, 16'h0001, 16'h0, 8'h0, 4'h0);
    drive(4'd7, 3'd0, 16'hFFFF, 16'hBEEF, 8'h0, 4'h3);
    drive(4'd8, 3'd0, 16'hFFFE, 16'h12AB, 8'h0, 4'h0);
    drive(4'd8, 3'd0, 16'h8000, 16'h00F0, 8'h0, 4'h3);
    idle();
    idle();
    // R2 a quiet cycle leaves out_valid low
    chk("R2", "out_valid idle", {15'h0, out_valid}, 16'h0);

    // R8 / R9 every condition against both flag states
    for (int cc = 0; cc < 8; cc++) begin
      for (int fv = 0; fv < 4; fv++) begin
        drive(4'd9, 3'(cc), 16'h4000, 16'h0, 8'h10, {fv[1], 2'b00, fv[0]});
      end
    end
    drive(4'd9, 3'd0, 16'h0000, 16'h0, 8'h80, 4'h0);
    drive(4'd9, 3'd0, 16'hFFFF, 16'h0, 8'h7F, 4'h0);
    drive(4'd9, 3'd2, 16'h0010, 16'h0, 8'h80, 4'h0);
    // R10 no-op and unused codes
    for (int oc = 10; oc < 16; oc++) drive(4'(oc), 3'd0, 16'hA5A5, 16'h5A5A, 8'h80, 4'h9);
    drive(4'd0, 3'd0, 16'h1357, 16'h0, 8'h0, 4'h6);

    // random traffic with occasional gaps
    for (int i = 0; i < 400; i++) begin
      drive(4'($urandom_range(0, 15)), 3'($urandom_range(0, 7)), 16'($urandom),
            16'($urandom), 8'($urandom), 4'($urandom));
      if ((i % 37) == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    chk("R2", "pending results", 16'(q.size()), 16'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule